// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block provides a set of identical local timer channels, one per processor core. Each channel chains two down-counters. A prescaler stage divides the input clock into ticks. An event stage counts those ticks and flags an expiry when it runs out. Software programs each channel through a 32-bit register bus. The channels are spaced at a fixed stride in the address space, and each channel drives its own interrupt line.

The event stage is a two-state machine. In state `IC_IDLE` it keeps its counter preloaded from the reload buffer. The transition *arm* (event-start bit set) moves it to `IC_COUNT`. In `IC_COUNT` each tick decrements the counter. When a tick arrives with the counter at zero, the channel flags an expiry. The machine leaves `IC_COUNT` for `IC_IDLE` on two transitions:
- *halt*: the event-start bit is cleared.
- *oneshot_end*: an expiry occurs with interval mode off.

In interval mode an expiry reloads the counter and counting continues. The prescaler has no states. While its start bit is clear it holds its reload value, and while the bit is set it counts down and wraps.

Every bus write passes through one pipeline register. A write captured on one clock edge is applied on the following edge. Writes to the tick buffer, the event buffer and the control register each set a write-status flag, which lets software confirm that the new value has landed.

Top module: `lcl_tick_timer`

## Requirements
- R1: After reset every channel register reads 0 and every irq line is low.
- R2: Channel n is decoded at 0x300 + 0x100*n. Inside a channel the registers are at these offsets: tick buffer 0x00, event buffer 0x08, control 0x20, status 0x30, enable 0x34, write status 0x40. Any other address reads 0.
- R3: A write captured on one clock edge becomes visible in registers and counters only on the next edge, so the value reads back two cycles after it was driven.
- R4: Applying a write sets a write-status bit: tick buffer sets bit 0, event buffer sets bit 1, control sets bit 3. Writing 1 to a bit of the write-status register clears it.
- R5: While control bit 0 is set, the prescaler emits one tick every N+1 clocks, where N is the tick buffer. Clearing the bit stops ticking at once. Setting it again restarts the count from N.
- R6: Once the event stage is counting (control bit 1), a loaded value V expires on the (V+1)-th tick. A value of 0 expires on the first tick.
- R7: With control bit 2 set, an expiry reloads the counter from the event buffer and expiries keep repeating.
- R8: With control bit 2 clear, the event stage stops after one expiry and control bit 1 reads back 0.
- R9: A write to the event buffer with bit 31 set also loads the active counter at once. Without bit 31 only the buffer changes, and the new value takes effect at the next reload. Bit 31 reads back 0.
- R10: Status bit 0 sets on every expiry. Writing 1 clears it, writing 0 leaves it unchanged, and a new expiry wins over a simultaneous clear.
- R11: A channel's irq is high exactly when its status bit 0 and enable bit 0 are both 1.
- R12: Channels are independent. Writes, starts and stops on one channel never change another.
- R13: Buffer bits above the configured counter width are discarded on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
The bench builds the block with two channels, an 8-bit prescaler and a 16-bit event counter. With two channels, the decode of the second page and an unmapped page above it can both be checked. The narrow widths make truncation of over-wide buffer writes observable. Small reload values keep many expiry periods, one-shot completions and reload changes within a few hundred cycles. A behavioural model predicts the irq lines on every clock and the value of every register read.

// File: rtl/lcl_tick_pkg.sv
`timescale 1ns/1ps
package lcl_tick_pkg;
    localparam int ADDR_W = 12;
    localparam logic [3:0] FIRST_PAGE = 4'h3;
    localparam logic [7:0] OFF_TBUF = 8'h00;
    localparam logic [7:0] OFF_IBUF = 8'h08;
    localparam logic [7:0] OFF_CTRL = 8'h20;
    localparam logic [7:0] OFF_ISTA = 8'h30;
    localparam logic [7:0] OFF_IEN  = 8'h34;
    localparam logic [7:0] OFF_WST  = 8'h40;
    localparam int CTL_TICK_RUN = 0;
    localparam int CTL_EVT_RUN  = 1;
    localparam int CTL_INTERVAL = 2;
    localparam int WST_TBUF = 0;
    localparam int WST_IBUF = 1;
    localparam int WST_CTRL = 3;
    localparam int UPD_BIT  = 31;

    typedef enum logic {
        IC_IDLE  = 1'b0,
        IC_COUNT = 1'b1
    } evt_state_t;
endpackage

// File: rtl/ltt_prescaler.sv
`timescale 1ns/1ps
module ltt_prescaler #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] reload,
    output logic              tick
);
    logic [TICK_W-1:0] cnt_q;

    always_comb tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= reload;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - TICK_W'(1);
        end
    end
endmodule

// File: rtl/ltt_evtcnt.sv
`timescale 1ns/1ps
module ltt_evtcnt
    import lcl_tick_pkg::*;
#(
    parameter int ICNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              interval,
    input  logic              tick,
    input  logic              upd_load,
    input  logic [ICNT_W-1:0] upd_val,
    input  logic [ICNT_W-1:0] reload,
    output logic              expire,
    output logic              oneshot_done,
    output logic              counting
);
    evt_state_t        state_q, state_d;
    logic [ICNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IC_IDLE:  if (en) state_d = IC_COUNT;
            IC_COUNT: if (!en || oneshot_done) state_d = IC_IDLE;
        endcase
    end

    always_comb begin
        counting     = (state_q == IC_COUNT);
        expire       = counting && en && tick && (cnt_q == '0);
        oneshot_done = expire && !interval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (upd_load) begin
            cnt_q <= upd_val;
        end else if (state_q == IC_IDLE) begin
            cnt_q <= reload;
        end else if (en && tick) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - ICNT_W'(1);
        end
    end
endmodule

// File: rtl/ltt_chan_regs.sv
`timescale 1ns/1ps
module ltt_chan_regs
    import lcl_tick_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int TICK_W = 32,
    parameter int ICNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    input  logic              expire,
    input  logic              oneshot_done,
    output logic [TICK_W-1:0] tbuf,
    output logic [ICNT_W-1:0] ibuf,
    output logic              tick_run,
    output logic              evt_run,
    output logic              interval,
    output logic              upd_load,
    output logic [ICNT_W-1:0] upd_val,
    output logic              ista,
    output logic              irq,
    output logic              wst_tbuf
);
    localparam logic [3:0] PAGE = 4'(int'(FIRST_PAGE) + CH_IDX);

    logic        p_v;
    logic [7:0]  p_off;
    logic [31:0] p_d;
    logic [2:0]  ctrl_q;
    logic        ien_q;
    logic        wst_i_q, wst_c_q;
    logic        ap_tbuf, ap_ibuf, ap_ctrl, ap_ista, ap_ien, ap_wst;
    logic        sel_wr, sel_rd;

    always_comb begin
        sel_wr = bus_wr_en && (bus_addr[11:8] == PAGE);
        sel_rd = (bus_addr[11:8] == PAGE);
    end

    // capture stage: a write is held one cycle before it is applied
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_v   <= 1'b0;
            p_off <= '0;
            p_d   <= '0;
        end else begin
            p_v   <= sel_wr;
            p_off <= bus_addr[7:0];
            p_d   <= bus_wdata;
        end
    end

    always_comb begin
        ap_tbuf = p_v && (p_off == OFF_TBUF);
        ap_ibuf = p_v && (p_off == OFF_IBUF);
        ap_ctrl = p_v && (p_off == OFF_CTRL);
        ap_ista = p_v && (p_off == OFF_ISTA);
        ap_ien  = p_v && (p_off == OFF_IEN);
        ap_wst  = p_v && (p_off == OFF_WST);
        upd_load = ap_ibuf && p_d[UPD_BIT];
        upd_val  = p_d[ICNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbuf     <= '0;
            ibuf     <= '0;
            ctrl_q   <= '0;
            ien_q    <= 1'b0;
            ista     <= 1'b0;
            wst_tbuf <= 1'b0;
            wst_i_q  <= 1'b0;
            wst_c_q  <= 1'b0;
        end else begin
            if (ap_tbuf) tbuf <= p_d[TICK_W-1:0];
            if (ap_ibuf) ibuf <= p_d[ICNT_W-1:0];
            if (ap_ien)  ien_q <= p_d[0];

            if (ap_ctrl)           ctrl_q <= p_d[2:0];
            else if (oneshot_done) ctrl_q[CTL_EVT_RUN] <= 1'b0;

            if (expire)                  ista <= 1'b1;
            else if (ap_ista && p_d[0])  ista <= 1'b0;

            if (ap_tbuf)                       wst_tbuf <= 1'b1;
            else if (ap_wst && p_d[WST_TBUF])  wst_tbuf <= 1'b0;
            if (ap_ibuf)                       wst_i_q <= 1'b1;
            else if (ap_wst && p_d[WST_IBUF])  wst_i_q <= 1'b0;
            if (ap_ctrl)                       wst_c_q <= 1'b1;
            else if (ap_wst && p_d[WST_CTRL])  wst_c_q <= 1'b0;
        end
    end

    always_comb begin
        tick_run = ctrl_q[CTL_TICK_RUN];
        evt_run  = ctrl_q[CTL_EVT_RUN];
        interval = ctrl_q[CTL_INTERVAL];
        irq      = ista && ien_q;
    end

    always_comb begin
        rd_data = '0;
        if (sel_rd) begin
            unique case (bus_addr[7:0])
                OFF_TBUF: rd_data = 32'(tbuf);
                OFF_IBUF: rd_data = 32'(ibuf);
                OFF_CTRL: rd_data = {29'd0, ctrl_q};
                OFF_ISTA: rd_data = {31'd0, ista};
                OFF_IEN:  rd_data = {31'd0, ien_q};
                OFF_WST:  rd_data = {28'd0, wst_c_q, 1'b0, wst_i_q, wst_tbuf};
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ltt_channel.sv
`timescale 1ns/1ps
module ltt_channel
    import lcl_tick_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int TICK_W = 32,
    parameter int ICNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic              irq,
    output logic              tick,
    output logic              expire,
    output logic              counting,
    output logic              interval,
    output logic              ista,
    output logic              tbuf_zero,
    output logic              wst_tbuf
);
    logic [TICK_W-1:0] tbuf;
    logic [ICNT_W-1:0] ibuf, upd_val;
    logic              tick_run, evt_run, upd_load, oneshot_done;

    ltt_chan_regs #(.CH_IDX(CH_IDX), .TICK_W(TICK_W), .ICNT_W(ICNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .expire(expire),
        .oneshot_done(oneshot_done), .tbuf(tbuf), .ibuf(ibuf),
        .tick_run(tick_run), .evt_run(evt_run), .interval(interval),
        .upd_load(upd_load), .upd_val(upd_val), .ista(ista), .irq(irq),
        .wst_tbuf(wst_tbuf)
    );

    ltt_prescaler #(.TICK_W(TICK_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(tick_run), .reload(tbuf), .tick(tick)
    );

    ltt_evtcnt #(.ICNT_W(ICNT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .en(evt_run), .interval(interval), .tick(tick),
        .upd_load(upd_load), .upd_val(upd_val), .reload(ibuf),
        .expire(expire), .oneshot_done(oneshot_done), .counting(counting)
    );

    always_comb tbuf_zero = (tbuf == '0);
endmodule

// File: rtl/lcl_tick_timer.sv
`timescale 1ns/1ps
module lcl_tick_timer
    import lcl_tick_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TICK_W = 32,
    parameter int ICNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [31:0]       ch_rd [NUM_CH];
    logic [NUM_CH-1:0] ch_tick, ch_expire, ch_counting, ch_interval;
    logic [NUM_CH-1:0] ch_ista, ch_tbuf_zero, ch_wst_tbuf;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ltt_channel #(.CH_IDX(g), .TICK_W(TICK_W), .ICNT_W(ICNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
            .bus_wdata(bus_wdata), .rd_data(ch_rd[g]), .irq(irq[g]),
            .tick(ch_tick[g]), .expire(ch_expire[g]), .counting(ch_counting[g]),
            .interval(ch_interval[g]), .ista(ch_ista[g]),
            .tbuf_zero(ch_tbuf_zero[g]), .wst_tbuf(ch_wst_tbuf[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rd[i];
    end
endmodule

// File: rtl/ltt_checker.sv
`timescale 1ns/1ps
module ltt_checker
    import lcl_tick_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] ch_tick,
    input logic [NUM_CH-1:0] ch_expire,
    input logic [NUM_CH-1:0] ch_counting,
    input logic [NUM_CH-1:0] ch_interval,
    input logic [NUM_CH-1:0] ch_ista,
    input logic [NUM_CH-1:0] ch_tbuf_zero,
    input logic [NUM_CH-1:0] ch_wst_tbuf
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] TBUF_ADDR = ADDR_W'(12'h300 + 12'h100 * c);

        assert_expire_sets_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[c] |=> ch_ista[c]);

        assert_oneshot_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[c] && !ch_interval[c]) |=> !ch_counting[c]);

        assert_expire_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[c] |-> ch_tick[c]);

        assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[c] && !ch_tbuf_zero[c]) |=> !ch_tick[c]);

        assert_wst_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && bus_addr == TBUF_ADDR) |=> ##1 ch_wst_tbuf[c]);
    end
endmodule

bind lcl_tick_timer ltt_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .ch_tick(ch_tick), .ch_expire(ch_expire), .ch_counting(ch_counting),
    .ch_interval(ch_interval), .ch_ista(ch_ista), .ch_tbuf_zero(ch_tbuf_zero),
    .ch_wst_tbuf(ch_wst_tbuf)
);

// File: tb/lcl_tick_timer_bench.sv
`timescale 1ns/1ps
module lcl_tick_timer_bench;
    localparam int NUM_CH = 2;
    localparam int TICK_W = 8;
    localparam int ICNT_W = 16;
    localparam logic [31:0] TMASK = 32'h0000_00FF;
    localparam logic [31:0] IMASK = 32'h0000_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] irq;

    lcl_tick_timer #(.NUM_CH(NUM_CH), .TICK_W(TICK_W), .ICNT_W(ICNT_W)) u_lcl_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    irq_on = 1'b0;
    string cur_req = "R1";

    // behavioural reference model, advanced on every rising edge
    logic [31:0] m_tbuf[NUM_CH], m_ibuf[NUM_CH], m_ctrl[NUM_CH], m_ista[NUM_CH];
    logic [31:0] m_ien[NUM_CH], m_wst[NUM_CH], m_tcnt[NUM_CH], m_icnt[NUM_CH];
    bit          m_cnting[NUM_CH];
    bit          q_v;
    logic [11:0] q_a;
    logic [31:0] q_d;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                m_tbuf[c] = 0; m_ibuf[c] = 0; m_ctrl[c] = 0; m_ista[c] = 0;
                m_ien[c] = 0; m_wst[c] = 0; m_tcnt[c] = 0; m_icnt[c] = 0;
                m_cnting[c] = 0;
            end
            q_v = 0; q_a = 0; q_d = 0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                bit hit, tk, en, iv, ex, os;
                logic [7:0] off;
                logic [31:0] n_tcnt, n_icnt, n_ctrl;
                hit = q_v && (int'(q_a[11:8]) == 3 + c);
                off = q_a[7:0];
                tk  = m_ctrl[c][0] && (m_tcnt[c] == 0);
                en  = m_ctrl[c][1];
                iv  = m_ctrl[c][2];
                ex  = m_cnting[c] && en && tk && (m_icnt[c] == 0);
                os  = ex && !iv;
                if (!m_ctrl[c][0] || m_tcnt[c] == 0) n_tcnt = m_tbuf[c];
                else n_tcnt = m_tcnt[c] - 1;
                if (hit && off == 8'h08 && q_d[31]) n_icnt = q_d & IMASK;
                else if (!m_cnting[c]) n_icnt = m_ibuf[c];
                else if (en && tk) n_icnt = (m_icnt[c] == 0) ? m_ibuf[c] : m_icnt[c] - 1;
                else n_icnt = m_icnt[c];
                m_cnting[c] = m_cnting[c] ? (en && !os) : en;
                n_ctrl = m_ctrl[c];
                if (hit && off == 8'h20) n_ctrl = q_d & 32'h7;
                else if (os) n_ctrl = m_ctrl[c] & ~32'h2;
                if (ex) m_ista[c] = 1;
                else if (hit && off == 8'h30 && q_d[0]) m_ista[c] = 0;
                if (hit && off == 8'h34) m_ien[c] = q_d & 32'h1;
                if (hit && off == 8'h40) m_wst[c] = m_wst[c] & ~(q_d & 32'hB);
                if (hit && off == 8'h00) begin m_tbuf[c] = q_d & TMASK; m_wst[c] |= 32'h1; end
                if (hit && off == 8'h08) begin m_ibuf[c] = q_d & IMASK; m_wst[c] |= 32'h2; end
                if (hit && off == 8'h20) m_wst[c] |= 32'h8;
                m_ctrl[c] = n_ctrl; m_tcnt[c] = n_tcnt; m_icnt[c] = n_icnt;
            end
            q_v = bus_wr_en; q_a = bus_addr; q_d = bus_wdata;
        end
    end

    function automatic logic [31:0] mread(input logic [11:0] a);
        int pg;
        pg = int'(a[11:8]) - 3;
        if (pg < 0 || pg >= NUM_CH) return 0;
        case (a[7:0])
            8'h00: return m_tbuf[pg];
            8'h08: return m_ibuf[pg];
            8'h20: return m_ctrl[pg];
            8'h30: return m_ista[pg];
            8'h34: return m_ien[pg];
            8'h40: return m_wst[pg];
            default: return 0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // irq lines are compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && irq_on && !done) begin
            for (int c = 0; c < NUM_CH; c++)
                check(32'(irq[c]), m_ista[c] & m_ien[c], cur_req, $sformatf("irq[%0d]", c));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        @(negedge clk); bus_addr = a; #1;
        check(bus_rdata, mread(a), req, $sformatf("read %h", a));
    endtask

    task automatic rd_lit(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); bus_addr = a; #1;
        check(bus_rdata, exp, req, $sformatf("read %h", a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_on = 1'b1;
        // R1: reset state
        cur_req = "R1";
        for (int c = 0; c < NUM_CH; c++) begin
            rd_lit(12'(12'h300 + c * 12'h100), 0, "R1");
            rd_lit(12'(12'h308 + c * 12'h100), 0, "R1");
            rd_lit(12'(12'h320 + c * 12'h100), 0, "R1");
            rd_lit(12'(12'h340 + c * 12'h100), 0, "R1");
        end
        check(32'(irq), 0, "R1", "irq after reset");

        // R2: decode of pages and offsets
        cur_req = "R2";
        wr(12'h434, 1);
        rd_lit(12'h434, 1, "R2");
        rd_lit(12'h334, 0, "R2");
        rd_lit(12'h534, 0, "R2");
        rd_lit(12'h238, 0, "R2");
        rd_lit(12'h410, 0, "R2");

        // R3: value is not visible one edge after capture, visible after the next
        cur_req = "R3";
        @(negedge clk); bus_wr_en = 1'b1; bus_addr = 12'h300; bus_wdata = 32'h5;
        @(negedge clk); bus_wr_en = 1'b0; #1;
        check(bus_rdata, 0, "R3", "tick buffer before apply");
        @(negedge clk); #1;
        check(bus_rdata, 5, "R3", "tick buffer after apply");

        // R13: truncation to the configured widths
        cur_req = "R13";
        wr(12'h300, 32'h1FF);
        rd_lit(12'h300, 32'hFF, "R13");
        wr(12'h308, 32'h0001_2345);
        rd_lit(12'h308, 32'h2345, "R13");

        // R4: write-status set and clear
        cur_req = "R4";
        wr(12'h320, 0);
        rd_lit(12'h340, 32'hB, "R4");
        wr(12'h340, 32'h2);
        rd_lit(12'h340, 32'h9, "R4");
        wr(12'h340, 32'hF);
        rd_lit(12'h340, 0, "R4");

        // R5 R6 R7 R11: interval mode, tick every 4 clocks, expiry every 3 ticks
        cur_req = "R7";
        wr(12'h300, 3);
        wr(12'h308, 32'h8000_0002);
        wr(12'h320, 7);
        idle(60);
        cur_req = "R11";
        wr(12'h330, 1);
        idle(5);
        rd(12'h330, "R11");
        wr(12'h330, 1);
        idle(30);

        // R10: writing 0 leaves status untouched
        cur_req = "R10";
        idle(20);
        wr(12'h330, 0);
        rd_lit(12'h330, 1, "R10");
        wr(12'h330, 1);
        rd(12'h330, "R10");

        // R9: buffer change without update flag takes effect on the next reload
        cur_req = "R9";
        wr(12'h308, 32'h0000_0005);
        rd_lit(12'h308, 5, "R9");
        for (int k = 0; k < 8; k++) begin
            idle(6);
            wr(12'h330, 1);
        end
        wr(12'h308, 32'h8000_0001);
        rd_lit(12'h308, 1, "R9");
        idle(40);

        // R5: stopping the prescaler freezes expiries
        cur_req = "R5";
        wr(12'h320, 6);
        wr(12'h330, 1);
        idle(50);
        rd_lit(12'h330, 0, "R5");
        wr(12'h320, 7);
        idle(30);
        rd(12'h330, "R5");

        // R8: one-shot completes once and drops the event-start bit
        cur_req = "R8";
        wr(12'h320, 0);
        wr(12'h300, 1);
        wr(12'h308, 32'h8000_0002);
        wr(12'h330, 1);
        wr(12'h320, 3);
        idle(20);
        rd_lit(12'h320, 1, "R8");
        rd_lit(12'h330, 1, "R8");
        wr(12'h330, 1);
        idle(20);
        rd_lit(12'h330, 0, "R8");

        // R6: zero reload expires on the first counted tick
        cur_req = "R6";
        wr(12'h320, 0);
        wr(12'h300, 2);
        wr(12'h308, 32'h8000_0000);
        wr(12'h330, 1);
        wr(12'h320, 3);
        idle(12);
        rd_lit(12'h330, 1, "R6");
        rd(12'h320, "R6");

        // R12: channel 1 runs on while channel 0 is reprogrammed and stopped
        cur_req = "R12";
        wr(12'h400, 1);
        wr(12'h408, 32'h8000_0003);
        wr(12'h420, 7);
        wr(12'h334, 1);
        wr(12'h320, 7);
        idle(30);
        wr(12'h320, 0);
        wr(12'h300, 9);
        rd_lit(12'h400, 1, "R12");
        rd_lit(12'h420, 7, "R12");
        idle(40);
        rd(12'h430, "R12");
        rd(12'h440, "R12");

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule